// File: doc/BRIEF.md
# Binary/Decimal Selectable Digit Adder

This block adds two 4-bit operands and an incoming carry, and it can produce either of two results. With the decimal-select pin low, it works as an ordinary unsigned binary adder. It returns the low four bits of the total and the carry out of the top bit. With the pin high, it treats both operands as single decimal digits (0 to 9). It corrects the binary total back into one decimal digit and a decimal carry.

The arithmetic runs on a ripple chain of four identical full-adder slices. The binary and decimal modes share that chain. A small correction stage follows it and is active only in decimal mode. The block has no registers, so its outputs follow its inputs after propagation delay. Wider numbers are built by connecting the carry out of one digit to the carry in of the next, with the lowest digit first.

Top module: `dm_digit_adder`

## Requirements
- R1: With `mode_i` = 0, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` as an unsigned 5-bit value, for every operand and carry value.
- R2: With `mode_i` = 1 and both operands in 0..9, `sum_o` equals `(a_i + b_i + cin_i) mod 10` and `cout_o` equals 1 exactly when that total is 10 or more.
- R3: With `mode_i` = 1, when the binary total exceeds 9 or carries out of bit 3, `cout_o` is 1 and `sum_o` is the low four bits of the binary total plus 6.
- R4: With `mode_i` = 1, when the binary total is 9 or less, `sum_o` equals that total unchanged and `cout_o` is 0.
- R5: With `mode_i` = 0, no decimal correction is applied even when the total is 10 to 15 (for example 7 + 5 gives `sum_o` = 4'b1100 and `cout_o` = 0).
- R6: When the carry out of a decimal-mode digit drives the carry in of a second digit, the pair returns the correct two-digit decimal sum for all operand pairs from 00 to 99.
- R7: The outputs are purely combinational. A change on any input shows on the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand (one decimal digit in decimal mode) |
| b_i | input | 4 | Second operand (one decimal digit in decimal mode) |
| cin_i | input | 1 | Carry in from the next lower digit |
| mode_i | input | 1 | 0 = binary addition, 1 = decimal digit addition |
| sum_o | output | 4 | Sum digit |
| cout_o | output | 1 | Carry out to the next higher digit |

## Verification
The decimal-mode assertions assume both operands are valid decimal digits (9 or less). Each of them is guarded by that condition, so codes 10 to 15 in decimal mode never trigger them. The binary-mode assertions hold for any input. The bench sweeps every binary combination. In decimal mode it drives only digits 0 to 9, which keeps it inside the assumed input range. It then chains two instances and sweeps every two-digit pair.

// File: rtl/dm_add_pkg.sv
package dm_add_pkg;
  parameter int DIGIT_W = 4;
  localparam int DEC_MAX = 9;
  localparam int DEC_FIX = 6;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

  // decimal overflow: carry out of the top bit, or a 4-bit value above nine
  function automatic logic dec_over(input logic [DIGIT_W-1:0] raw, input logic c_top);
    return c_top | (raw > DIGIT_W'(DEC_MAX));
  endfunction

  function automatic logic [DIGIT_W-1:0] dec_adjust(input logic [DIGIT_W-1:0] raw);
    return raw + DIGIT_W'(DEC_FIX);
  endfunction
endpackage

// File: rtl/dm_fa_slice.sv
module dm_fa_slice
  import dm_add_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = fa_sum(x_i, y_i, c_i);
  assign c_o = fa_carry(x_i, y_i, c_i);
endmodule

// File: rtl/dm_ripple_add.sv
module dm_ripple_add
  import dm_add_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] chain_w;

  assign chain_w[0] = c_i;

  for (genvar g = 0; g < W; g++) begin : g_slice
    dm_fa_slice u_slice (
      .x_i (x_i[g]),
      .y_i (y_i[g]),
      .c_i (chain_w[g]),
      .s_o (s_o[g]),
      .c_o (chain_w[g+1])
    );
  end

  assign c_o = chain_w[W];
endmodule

// File: rtl/dm_dec_fix.sv
module dm_dec_fix
  import dm_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] raw_i,
  input  logic               raw_c_i,
  input  logic               dec_i,
  output logic [DIGIT_W-1:0] sum_o,
  output logic               cout_o,
  output logic               fix_o
);
  logic over_w;

  assign over_w = dec_over(raw_i, raw_c_i);
  assign fix_o  = dec_i & over_w;
  assign sum_o  = fix_o ? dec_adjust(raw_i) : raw_i;
  assign cout_o = dec_i ? fix_o : raw_c_i;

  always_comb begin
    AST_FIX_FORCES_CARRY: assert (!fix_o || cout_o) else $error("correction without carry"); // R3
  end
endmodule

// File: rtl/dm_digit_adder.sv
module dm_digit_adder
  import dm_add_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  input  logic       mode_i,
  output logic [3:0] sum_o,
  output logic       cout_o
);
  localparam int W = DIGIT_W;

  logic [W-1:0] raw_sum_w;
  logic         raw_carry_w;
  logic         fix_w;
  logic         ops_dec_w;
  logic [W:0]   total_w;

  dm_ripple_add #(.W(W)) u_add (
    .x_i (a_i),
    .y_i (b_i),
    .c_i (cin_i),
    .s_o (raw_sum_w),
    .c_o (raw_carry_w)
  );

  dm_dec_fix u_fix (
    .raw_i   (raw_sum_w),
    .raw_c_i (raw_carry_w),
    .dec_i   (mode_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .fix_o   (fix_w)
  );

  assign ops_dec_w = (a_i <= W'(DEC_MAX)) && (b_i <= W'(DEC_MAX));
  assign total_w   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    AST_BIN_EXACT: assert (mode_i || ({cout_o, sum_o} == total_w)) else $error("binary total mismatch"); // R1
    AST_BCD_DIGIT: assert (!(mode_i && ops_dec_w) || (sum_o <= W'(DEC_MAX))) else $error("decimal digit out of range"); // R2
    AST_BCD_CARRY: assert (!(mode_i && ops_dec_w) || (cout_o == (total_w >= (W+1)'(10)))) else $error("decimal carry wrong"); // R2
    AST_BCD_PASS: assert (!(mode_i && !raw_carry_w && raw_sum_w <= W'(DEC_MAX)) || (sum_o == raw_sum_w && !cout_o)) else $error("small decimal sum altered"); // R4
    AST_BIN_NO_FIX: assert (mode_i || (sum_o == raw_sum_w && !fix_w)) else $error("correction in binary mode"); // R5
  end
endmodule

// File: tb/test_dm_digit_adder.sv
module test_dm_digit_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] a, b, a_hi, b_hi;
  logic       cin, mode;
  logic [3:0] sum, sum_hi;
  logic       cout, cout_hi;
  int n_chk = 0;
  int n_fail = 0;

  dm_digit_adder i_dm_digit_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .mode_i(mode), .sum_o(sum), .cout_o(cout)
  );

  dm_digit_adder i_hi (
    .a_i(a_hi), .b_i(b_hi), .cin_i(cout), .mode_i(1'b1), .sum_o(sum_hi), .cout_o(cout_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d cin=%0d mode=%0d actual=%0d expected=%0d",
               req, a, b, cin, mode, act, exp);
    end
  endtask

  task automatic drive(input int x, input int y, input int c, input int m);
    a = 4'(x); b = 4'(y); cin = 1'(c); mode = 1'(m);
    #1;
  endtask

  // R1, R5: all binary combinations
  task automatic t_binary();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int c = 0; c < 2; c++) begin
          drive(x, y, c, 0);
          check((x + y + c >= 10 && x + y + c <= 15) ? "R5" : "R1",
                {27'd0, cout, sum}, x + y + c);
        end
  endtask

  // R2, R3, R4: all decimal digit combinations
  task automatic t_decimal();
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        for (int c = 0; c < 2; c++) begin
          int t;
          t = x + y + c;
          drive(x, y, c, 1);
          check("R2", int'(sum), t % 10);
          if (t > 9) begin
            check("R3", int'(cout), 1);
            check("R3", int'(sum), (t + 6) % 16);
          end else begin
            check("R4", int'(cout), 0);
            check("R4", int'(sum), t);
          end
        end
  endtask

  // R5: explicit case 7 + 5
  task automatic t_no_fix();
    drive(7, 5, 0, 0);
    check("R5", int'(sum), 12);
    check("R5", int'(cout), 0);
  endtask

  // R7: mode flip alone changes outputs with no clock edge
  task automatic t_comb();
    time t0;
    drive(8, 4, 0, 0);
    t0 = $time;
    check("R7", int'(sum), 12);
    mode = 1'b1;
    #0.5;
    check("R7", int'(sum), 2);
    check("R7", int'(cout), 1);
    check("R7", int'($time - t0 < 5), 1);
  endtask

  // R6: two chained digits, all pairs 00..99
  task automatic t_chain();
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y++) begin
        int t;
        a_hi = 4'(x / 10); b_hi = 4'(y / 10);
        drive(x % 10, y % 10, 0, 1);
        t = x + y;
        check("R6", int'(cout_hi) * 100 + int'(sum_hi) * 10 + int'(sum), t);
      end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    a_hi = '0; b_hi = '0;
    drive(0, 0, 0, 0);
    check("R1", int'(sum), 0);
    check("R1", int'(cout), 0);
    t_binary();
    t_decimal();
    t_no_fix();
    t_comb();
    t_chain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule